// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit

A sequential integer arithmetic unit for a small multi-cycle processor core. The core presents two 16-bit operands with an operation select (multiply or divide) and a signed/unsigned flag, and pulses `start`. The unit then iterates one step per clock and reports completion with a one-cycle `done` pulse. For a multiply, `res_main` carries the low 16 bits of the product. For a divide, `res_main` carries the quotient and `res_aux` the remainder.

Multiplication is shift-and-add, and it finishes as soon as no set multiplier bits are left. Its latency therefore depends on the data. Division is restoring and always runs the full 16 iterations. In signed mode the unit works on magnitudes and corrects the signs of the results at the end.

Top module: `muldiv_iter`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `res_main` and `res_aux` are 0.
- R2: A `start` sampled with `busy` low is accepted. `busy` is 1 from the next cycle for exactly N cycles. `done` is then 1 for one cycle with `busy` 0, and the results are valid in that cycle.
- R3: For a multiply (`op_div`=0), N equals the 1-based position of the highest set bit of the second operand's magnitude (0x0001 gives 1, 0x8000 gives 16). A second operand of zero gives N=1 and a product of 0.
- R4: For a multiply, `res_main` is the low 16 bits of a*b and `res_aux` is 0. In signed mode (`is_signed`=1) both operands are read as two's complement.
- R5: For a divide (`op_div`=1), N is always 16, whatever the operand values.
- R6: An unsigned divide gives quotient = a/b in `res_main` and remainder = a mod b in `res_aux`.
- R7: A signed divide rounds the quotient toward zero, so the quotient is negative when the operand signs differ. The remainder has the sign of the dividend. Results wrap to 16 bits (-32768 / -1 gives 0x8000).
- R8: A divide by zero gives a quotient of 0xFFFF and a remainder equal to the dividend, in both modes, and still takes 16 cycles.
- R9: A `start` while `busy` is 1 is ignored. It changes neither the latency nor the results of the running operation.
- R10: `res_main` and `res_aux` change only in the cycle where `done` is 1. They hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| is_signed | input | 1 | 1 = two's complement operands |
| opa | input | 16 | Multiplicand or dividend |
| opb | input | 16 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_main | output | 16 | Product low half or quotient |
| res_aux | output | 16 | Remainder (0 after multiply) |

## Verification
A wrong iteration count shows on the ports at once: `done` arrives one or more cycles early or late against the latency the bench model predicts from the operand. A corrupted accumulator or quotient register, or a wrong sign-correction flag, only shows in the `done` cycle as a wrong `res_main` or `res_aux`. For that reason every operation checks the result value as well as the exact completion cycle. A stray `start` taken while `busy` is high would reload the operands, and would show both as a changed latency and as a changed result.

// File: rtl/muldiv_iter.sv
module muldiv_iter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_div,
  input  logic         is_signed,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_main,
  output logic [W-1:0] res_aux
);
  localparam int CW = $clog2(W) + 1;

  logic [W-1:0]  acc, mpl, mcd;
  logic [CW-1:0] cnt;
  logic          op_q, neg_q, neg_r, bzero;

  wire          a_neg = is_signed & opa[W-1];
  wire          b_neg = is_signed & opb[W-1];
  wire [W-1:0]  a_mag = a_neg ? -opa : opa;
  wire [W-1:0]  b_mag = b_neg ? -opb : opb;

  function automatic logic [CW-1:0] top_bit(input logic [W-1:0] v);
    logic [CW-1:0] p;
    p = CW'(1);
    for (int i = 0; i < W; i++)
      if (v[i]) p = CW'(i + 1);
    return p;
  endfunction

  wire [W-1:0] mul_acc = acc + (mpl[0] ? mcd : '0);
  wire [W:0]   shifted = {acc, mpl[W-1]};
  wire         fits    = shifted >= {1'b0, mcd};
  wire [W:0]   diff    = shifted - {1'b0, mcd};
  wire [W-1:0] div_rem = fits ? diff[W-1:0] : shifted[W-1:0];
  wire [W-1:0] div_quo = {mpl[W-2:0], fits};
  wire         last    = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; cnt <= '0;
      acc <= '0; mpl <= '0; mcd <= '0;
      op_q <= 1'b0; neg_q <= 1'b0; neg_r <= 1'b0; bzero <= 1'b0;
      res_main <= '0; res_aux <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          op_q  <= op_div;
          neg_q <= a_neg ^ b_neg;
          neg_r <= a_neg;
          bzero <= (opb == '0);
          acc   <= '0;
          mpl   <= op_div ? a_mag : b_mag;
          mcd   <= op_div ? b_mag : a_mag;
          cnt   <= op_div ? CW'(W) : top_bit(b_mag);
        end
      end else begin
        cnt <= cnt - CW'(1);
        if (op_q) begin
          acc <= div_rem;
          mpl <= div_quo;
        end else begin
          acc <= mul_acc;
          mpl <= mpl >> 1;
          mcd <= mcd << 1;
        end
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (op_q) begin
            res_main <= bzero ? '1 : (neg_q ? -div_quo : div_quo);
            res_aux  <= neg_r ? -div_rem : div_rem;
          end else begin
            res_main <= neg_q ? -mul_acc : mul_acc;
            res_aux  <= '0;
          end
        end
      end
    end
  end

  logic [CW:0] div_cycles;
  always_ff @(posedge clk) begin
    if (!rst_n)             div_cycles <= '0;
    else if (!busy && start) div_cycles <= '0;
    else if (busy)          div_cycles <= div_cycles + 1'b1;
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2
  busy_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
  // R2
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
  // R5
  div_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q) |-> (div_cycles == (CW+1)'(W)));
  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_main) && $stable(res_aux)));
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
endmodule

// File: tb/tb_muldiv_iter.sv
module tb_muldiv_iter;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op_div = 1'b0, is_signed = 1'b0;
  logic [15:0] opa = '0, opb = '0;
  logic busy, done;
  logic [15:0] res_main, res_aux;
  int total = 0, bad = 0;

  muldiv_iter dut (.clk, .rst_n, .start, .op_div, .is_signed, .opa, .opb,
                   .busy, .done, .res_main, .res_aux);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lat_mul(input logic [15:0] b, input logic sg);
    int m, p;
    m = (sg && b[15]) ? (65536 - int'(b)) : int'(b);
    p = 1;
    for (int i = 0; i < 17; i++) if (m >= (1 << i)) p = i + 1;
    return p;
  endfunction

  task automatic run_op(input string req, input logic d, input logic sg,
                        input logic [15:0] a, input logic [15:0] b, input bit poke);
    int n, sa, sb;
    logic [15:0] em, ex;
    sa = sg ? int'($signed(a)) : int'(a);
    sb = sg ? int'($signed(b)) : int'(b);
    if (!d) begin
      n = lat_mul(b, sg);
      em = 16'(sa * sb);
      ex = '0;
    end else begin
      n = 16;
      if (b == 0) begin em = 16'hFFFF; ex = a; end
      else begin em = 16'(sa / sb); ex = 16'(sa % sb); end
    end
    start = 1'b1; op_div = d; is_signed = sg; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk({req, " busy"}, {31'd0, busy}, 32'd1);
      chk({req, " no early done"}, {31'd0, done}, 32'd0);
      if (poke && i == 1) begin
        start = 1'b1; op_div = ~d; opa = ~a; opb = 16'h0001; // R9
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk({req, " done"}, {30'd0, done, busy}, 32'd2);
    chk({req, " main"}, {16'd0, res_main}, {16'd0, em});
    chk({req, " aux"}, {16'd0, res_aux}, {16'd0, ex});
    @(negedge clk);
    chk({req, " R2 pulse"}, {31'd0, done}, 32'd0);
    chk({req, " R10 hold"}, {res_main, res_aux}, {em, ex});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {busy, done, res_main, res_aux}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle", {30'd0, busy, done}, 32'd0);
    run_op("R3 R4 mul b0", 0, 0, 16'h1234, 16'h0000, 0);
    run_op("R3 R4 mul b1", 0, 0, 16'h1234, 16'h0001, 0);
    run_op("R3 R4 mul", 0, 0, 16'h0123, 16'h0035, 0);
    run_op("R3 R4 mul top", 0, 0, 16'h0003, 16'h8001, 0);
    run_op("R4 mul signed", 0, 1, 16'hFFFD, 16'h0007, 0);
    run_op("R3 R4 mul signed negb", 0, 1, 16'h0011, 16'hFFF0, 0);
    run_op("R3 mul signed minb", 0, 1, 16'h0005, 16'h8000, 0);
    run_op("R5 R6 div", 1, 0, 16'd1000, 16'd7, 0);
    run_op("R5 R6 div big", 1, 0, 16'hFFFF, 16'h8000, 0);
    run_op("R5 R6 div small", 1, 0, 16'd3, 16'd10, 0);
    run_op("R7 div s -/+", 1, 1, 16'hFFF9, 16'd2, 0);
    run_op("R7 div s +/-", 1, 1, 16'd7, 16'hFFFE, 0);
    run_op("R7 div s -/-", 1, 1, 16'hFFF9, 16'hFFFE, 0);
    run_op("R7 div wrap", 1, 1, 16'h8000, 16'hFFFF, 0);
    run_op("R8 div0 u", 1, 0, 16'h1357, 16'h0000, 0);
    run_op("R8 div0 s", 1, 1, 16'hF00D, 16'h0000, 0);
    run_op("R9 mul poke", 0, 0, 16'h0042, 16'h0105, 1);
    run_op("R9 div poke", 1, 0, 16'd5000, 16'd33, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule